// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a direct-mapped cache. It sits between a processor-side access port and a main-memory port that is one word wide. A 32-bit byte address is divided into four fields: a tag, a line index, a word-within-line offset and a byte offset. Each line stores a tag and a valid flag next to its data words. A read whose line is valid and whose tag matches completes in the cycle it is presented.

On a read miss the requester is stalled. The controller first invalidates the selected line. It then fetches every word of the block from memory, lowest offset first. After the last word it stores the tag, marks the line valid and replays the access, which now hits. The write policy is write-through with write-allocate. A write to a resident line updates the cached word and sends the word to memory. A write to a non-resident line first refills the whole block, then performs that same write. The processor waits for the memory acknowledge on every write.

The processor holds `cpu_req` and its address, direction and write data steady until it sees `cpu_ready` high. The access completes at that clock edge. On the memory side a request is held steady until a one-cycle `mem_ack`; read data is taken in the acknowledge cycle.

Top module: `wt_dm_cache`

## Requirements
- R1: After reset every line is invalid: `cpu_ready` and `mem_req` are low, and the first read of any address misses and starts a refill.
- R2: With the default sizes, address bits [31:14] form the tag, [13:6] the line index and [5:2] the word offset. Bits [1:0] never affect which word is returned or whether the access hits. In general the fields are TAG_W, INDEX_W and OFFS_W bits wide, from the top down.
- R3: A read to a valid line with a matching tag raises `cpu_ready` in the same cycle as `cpu_req`, makes no memory request, and returns the stored word on `cpu_rdata`.
- R4: A read miss keeps `cpu_ready` low and issues exactly 2^OFFS_W memory reads (`mem_we` low). The first read is at the line base {tag, index, 0, 00}, and each later byte address is 4 above the previous one.
- R5: A line becomes valid only once its last refill word has arrived. The stalled access then completes and returns the word now held in memory at its address.
- R6: Two addresses with the same index and different tags evict each other, so alternating between them misses every time.
- R7: A write hit updates the cached word and makes exactly one memory write, with address {addr[31:2], 00} and the write data. No reads are made, and `cpu_ready` rises only in the cycle of that write's `mem_ack`.
- R8: A write miss makes a full line refill (R4), followed by exactly one memory write of the word. Afterwards the line is resident: the written word reads back as the new value, and the other words read back as the memory contents.
- R9: While `mem_req` is high without `mem_ack`, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R10: A valid line never hits for an access with the same index but a different tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |

## Verification
The situations hardest to reach from the ports are these:
- eviction of a line that was just written, where the value must come back from memory after the conflict miss;
- a write miss, where refill and write-through must occur in that order.

Directed addresses that share an index but differ in tag reach both. The bench runs a reduced configuration of 8 lines of 4 words. In that configuration it sweeps every line, every word and every byte offset. It then runs a pseudo-random stream over four tags, checked against an arithmetic model of the valid bits, the tags and the memory contents. A memory responder with a fixed latency counts reads and writes and checks address order. It also flags any request that changes while it is waiting.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] line_idx,
  input  logic               clr_en,
  input  logic               set_en,
  input  logic [TAG_W-1:0]   set_tag,
  output logic               line_valid,
  output logic [TAG_W-1:0]   line_tag
);

  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (clr_en) valid_q[line_idx] <= 1'b0;
      if (set_en) valid_q[line_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_mem[line_idx] <= set_tag;
  end

  assign line_valid = valid_q[line_idx];
  assign line_tag   = tag_mem[line_idx];

  // R1: the cycle after reset no line is valid
  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_q == '0));

  // R5: a completed refill leaves its line valid
  p_set_makes_valid_r5: assert property (@(posedge clk) disable iff (rst)
    set_en |=> valid_q[$past(line_idx)]);

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int AW     = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8,
  parameter int OFFS_W  = 4,
  parameter int TAG_W   = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic [INDEX_W-1:0] req_idx,
  input  logic [OFFS_W-1:0]  req_off,
  input  logic               hit,
  output logic               cpu_ready,
  output logic               tag_clr,
  output logic               tag_set,
  output logic               dat_we,
  output logic [OFFS_W-1:0]  dat_off,
  output logic [DATA_W-1:0]  dat_wdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack
);

  localparam logic [OFFS_W-1:0] LAST_OFF  = {OFFS_W{1'b1}};
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  dmc_state_e          state_q;
  logic [OFFS_W-1:0]   fill_cnt_q;
  logic                mem_req_q;
  logic                mem_we_q;
  logic [ADDR_W-1:0]   mem_addr_q;
  logic [DATA_W-1:0]   mem_wdata_q;

  logic idle_req, fill_ack, fill_last;

  assign idle_req  = (state_q == ST_IDLE) && cpu_req;
  assign fill_ack  = (state_q == ST_FILL) && mem_ack;
  assign fill_last = fill_ack && (fill_cnt_q == LAST_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      fill_cnt_q  <= '0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cpu_req && !hit) begin
            state_q    <= ST_FILL;
            fill_cnt_q <= '0;
            mem_req_q  <= 1'b1;
            mem_we_q   <= 1'b0;
            mem_addr_q <= {req_tag, req_idx, {OFFS_W{1'b0}}, 2'b00};
          end else if (cpu_req && cpu_we) begin
            state_q     <= ST_WRITE;
            mem_req_q   <= 1'b1;
            mem_we_q    <= 1'b1;
            mem_addr_q  <= {req_tag, req_idx, req_off, 2'b00};
            mem_wdata_q <= cpu_wdata;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            if (fill_cnt_q == LAST_OFF) begin
              state_q   <= ST_IDLE;
              mem_req_q <= 1'b0;
            end else begin
              fill_cnt_q <= fill_cnt_q + 1'b1;
              mem_addr_q <= mem_addr_q + WORD_STEP;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            state_q   <= ST_IDLE;
            mem_req_q <= 1'b0;
            mem_we_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cpu_ready = (idle_req && hit && !cpu_we) ||
                ((state_q == ST_WRITE) && mem_ack);
    tag_clr   = idle_req && !hit;
    tag_set   = fill_last;
    dat_we    = fill_ack || (idle_req && hit && cpu_we);
    dat_off   = (state_q == ST_FILL) ? fill_cnt_q : req_off;
    dat_wdata = (state_q == ST_FILL) ? mem_rdata : cpu_wdata;
  end

  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;

  // R3: completion is only signalled for a pending request
  p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> cpu_req);

  // R4: refill reads target the block of the stalled address
  p_fill_block_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |->
      (mem_req && !mem_we &&
       mem_addr[ADDR_W-1:OFFS_W+2] == {req_tag, req_idx}));

  // R5: the line being refilled never looks resident
  p_no_hit_in_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL) |-> !hit);

  // R7: a finished write coincides with the memory write being acknowledged
  p_write_through_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && cpu_we) |-> (mem_ack && mem_we));

  // R9: an unacknowledged request is held stable
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8,
  parameter int OFFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int TAG_W  = ADDR_W - INDEX_W - OFFS_W - 2;
  localparam int DAT_AW = INDEX_W + OFFS_W;
  localparam int OFF_LO = 2;
  localparam int IDX_LO = OFF_LO + OFFS_W;
  localparam int TAG_LO = IDX_LO + INDEX_W;

  logic [TAG_W-1:0]   req_tag;
  logic [INDEX_W-1:0] req_idx;
  logic [OFFS_W-1:0]  req_off;
  logic [1:0]         unused_byte_off;

  assign req_tag         = cpu_addr[ADDR_W-1:TAG_LO];
  assign req_idx         = cpu_addr[TAG_LO-1:IDX_LO];
  assign req_off         = cpu_addr[IDX_LO-1:OFF_LO];
  assign unused_byte_off = cpu_addr[1:0];

  logic               line_valid;
  logic [TAG_W-1:0]   line_tag;
  logic               hit;
  logic               tag_clr, tag_set;
  logic               dat_we;
  logic [OFFS_W-1:0]  dat_off;
  logic [DATA_W-1:0]  dat_wdata;

  assign hit = line_valid && (line_tag == req_tag);

  dmc_tag_store #(
    .INDEX_W (INDEX_W),
    .TAG_W   (TAG_W)
  ) tags_i (
    .clk        (clk),
    .rst        (rst),
    .line_idx   (req_idx),
    .clr_en     (tag_clr),
    .set_en     (tag_set),
    .set_tag    (req_tag),
    .line_valid (line_valid),
    .line_tag   (line_tag)
  );

  dmc_data_store #(
    .AW     (DAT_AW),
    .DATA_W (DATA_W)
  ) data_i (
    .clk     (clk),
    .wr_en   (dat_we),
    .wr_addr ({req_idx, dat_off}),
    .wr_data (dat_wdata),
    .rd_addr ({req_idx, req_off}),
    .rd_data (cpu_rdata)
  );

  dmc_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .INDEX_W (INDEX_W),
    .OFFS_W  (OFFS_W),
    .TAG_W   (TAG_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .req_tag   (req_tag),
    .req_idx   (req_idx),
    .req_off   (req_off),
    .hit       (hit),
    .cpu_ready (cpu_ready),
    .tag_clr   (tag_clr),
    .tag_set   (tag_set),
    .dat_we    (dat_we),
    .dat_off   (dat_off),
    .dat_wdata (dat_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack)
  );

  // R10: a reported hit always carries the requested tag
  p_hit_tag_match_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && !cpu_we) |-> (line_valid && line_tag == req_tag));

endmodule

// File: tb/wt_dm_cache_tb.sv
`timescale 1ns/1ps
module wt_dm_cache_tb_top;

  localparam int IW    = 3;
  localparam int OW    = 2;
  localparam int TW    = 32 - IW - OW - 2;
  localparam int WORDS = 1 << OW;
  localparam int LINES = 1 << IW;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  wt_dm_cache #(.ADDR_W(32), .DATA_W(32), .INDEX_W(IW), .OFFS_W(OW)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, fails = 0;
  logic [31:0] mstore [logic [31:0]];
  int nrd = 0, nwr = 0, bad_order = 0, hold_viol = 0, wait_cnt = 0;
  logic [31:0] first_rd = '0, last_rd = '0, wr_addr = '0, wr_data = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic        mv [LINES];
  logic [TW-1:0] mt [LINES];

  function automatic logic [31:0] mread(input logic [31:0] a);
    if (mstore.exists(a)) return mstore[a];
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int idx, input int wo, input int b);
    return {TW'(tg), IW'(idx), OW'(wo), 2'(b)};
  endfunction

  // memory responder: fixed latency, one-cycle ack, counts and order checks
  always @(negedge clk) begin
    if (pend && (!mem_req || mem_addr != pend_addr)) hold_viol++;
    if (rst || !mem_req || mem_ack) begin
      mem_ack = 1'b0;
      wait_cnt = 0;
    end else if (wait_cnt == LAT) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mstore[mem_addr] = mem_wdata;
        nwr++;
        wr_addr = mem_addr;
        wr_data = mem_wdata;
      end else begin
        mem_rdata = mread(mem_addr);
        if (nrd == 0) first_rd = mem_addr;
        else if (mem_addr != last_rd + 32'd4) bad_order++;
        last_rd = mem_addr;
        nrd++;
      end
    end else begin
      wait_cnt++;
    end
    pend = mem_req && !mem_ack;
    pend_addr = mem_addr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    nrd = 0; nwr = 0; bad_order = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    forever begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
      cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  // access checked against the model of valid bits, tags and memory
  task automatic run(input logic we, input logic [31:0] a, input logic [31:0] wd);
    int idx, cyc;
    logic [TW-1:0] tg;
    logic [31:0] rd, exp_rd, wa;
    bit exp_hit;
    idx = int'(a[OW+IW+1:OW+2]);
    tg  = a[31:OW+IW+2];
    wa  = {a[31:2], 2'b00};
    exp_hit = mv[idx] && (mt[idx] == tg);
    access(we, a, wd, rd, cyc);
    if (exp_hit) begin
      chk(nrd == 0, we ? "R7" : "R3", "reads on hit", nrd, 0);
      if (!we) chk(cyc == 0, "R3", "hit wait cycles", cyc, 0);
    end else begin
      // R4 / R8 / R10: a miss refills the full line in ascending order
      chk(nrd == WORDS, we ? "R8" : "R4", "refill read count", nrd, WORDS);
      chk(first_rd == {tg, IW'(idx), OW'(0), 2'b00}, "R4", "refill base", first_rd,
          {tg, IW'(idx), OW'(0), 2'b00});
      chk(bad_order == 0, "R4", "refill order errors", bad_order, 0);
      chk(cyc > 0, "R4", "miss stall cycles", cyc, 1);
    end
    if (we) begin
      chk(nwr == 1, exp_hit ? "R7" : "R8", "write-through count", nwr, 1);
      chk(wr_addr == wa, "R7", "write address", wr_addr, wa);
      chk(wr_data == wd, "R7", "write data", wr_data, wd);
    end else begin
      exp_rd = mread(wa);
      chk(nwr == 0, "R3", "writes on read", nwr, 0);
      chk(rd == exp_rd, exp_hit ? "R3" : "R5", "read data", rd, exp_rd);
    end
    mv[idx] = 1'b1;
    mt[idx] = tg;
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL R4 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf, rd;
    int cyc;
    for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk); #1;
    // R1: quiet outputs after reset
    chk(cpu_ready == 1'b0, "R1", "cpu_ready after reset", cpu_ready, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

    // R1 R4 R5: every line starts invalid and misses once
    for (int i = 0; i < LINES; i++) run(1'b0, mk(1, i, i % WORDS, 0), '0);

    // R2 R3: every word and byte offset now hits
    for (int i = 0; i < LINES; i++)
      for (int w = 0; w < WORDS; w++)
        for (int b = 0; b < 4; b++) begin
          run(1'b0, mk(1, i, w, b), '0);
          chk(nrd == 0, "R2", "byte offset caused miss", nrd, 0);
        end

    // R7: write hit then read back
    run(1'b1, mk(1, 2, 1, 0), 32'hCAFE_0001);
    access(1'b0, mk(1, 2, 1, 3), '0, rd, cyc);
    chk(rd == 32'hCAFE_0001, "R7", "write hit readback", rd, 32'hCAFE_0001);

    // R6 R10: conflicting tags on one index evict each other
    run(1'b0, mk(2, 2, 1, 0), '0);
    chk(nrd == WORDS, "R10", "other tag must miss", nrd, WORDS);
    run(1'b0, mk(1, 2, 1, 0), '0);
    chk(nrd == WORDS, "R6", "evicted line must miss", nrd, WORDS);
    chk(cpu_rdata == 32'hCAFE_0001, "R6", "written word from memory", cpu_rdata, 32'hCAFE_0001);
    run(1'b0, mk(2, 2, 0, 0), '0);
    chk(nrd == WORDS, "R6", "alternating miss", nrd, WORDS);

    // R8: write miss allocates, then whole line resident
    run(1'b1, mk(3, 5, 3, 0), 32'hBEEF_0303);
    for (int w = 0; w < WORDS; w++) begin
      run(1'b0, mk(3, 5, w, 0), '0);
      chk(nrd == 0, "R8", "line resident after write miss", nrd, 0);
    end

    // pseudo-random stream over four tags
    lf = 32'h1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run(lf[9:8] == 2'b00, mk(int'(lf[1:0]), int'(lf[4:2]), int'(lf[6:5]), int'(lf[11:10])),
          lf ^ 32'h0000_C0DE);
    end

    // R9: no request changed while waiting
    chk(hold_viol == 0, "R9", "request hold violations", hold_viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule